// File: doc/BRIEF.md
# Multiplexed 16-bit Memory Bus Master

This block runs single memory transactions over one shared 16-bit line set that carries the address first and the data afterwards. One mode strobe qualifies the line set. The core places a request with a direction flag, an address and a write word. The block then steps through four bus phases of one clock each. The first is a priming pulse with the strobe high. Next comes an address phase, then a direction phase in which the strobe level tells the peer whether a read or a write follows, and last a data phase. The core gets a one-cycle completion pulse and, for reads, the word the peer returned.

The shared lines are modelled as a separate output word, an output enable and an input word, so that a pad or tri-state buffer can be put at the chip edge. The block lets the lines float whenever it is not the one driving them. Words are 16 bits wide with the most significant byte at the lower address (big endian). For byte accesses the core may discard the low byte of a read word.

Top module: `membus_master`

## Requirements
- R1: A synchronous active-high reset, applied in any phase, returns the block to idle. From the next cycle the output enable is 0, the strobe is 0 and the completion pulse is 0.
- R2: In idle, a request with `req_valid` high at a clock edge is accepted. The next cycle is the priming phase: strobe 1 and output enable 0.
- R3: The cycle after priming is the address phase: output enable 1, `bus_out` equal to the accepted address, strobe 1.
- R4: The cycle after the address phase is the direction phase. The strobe is 0 for a write (`req_write`=1) and 1 for a read (`req_write`=0). `bus_out` still holds the address and the output enable stays 1.
- R5: In the data phase of a write, the output enable is 1, `bus_out` equals the accepted write word and the strobe is 0.
- R6: In the data phase of a read, the output enable is 0 and the strobe is 0. The whole 16-bit `bus_in` word is captured at the edge that ends this phase and appears on `rsp_rdata` from the next cycle. It holds that value until the next read completes, and writes leave it unchanged.
- R7: `rsp_done` is 1 for exactly the data-phase cycle, which is the fourth cycle after the accepting edge. It is 0 in every other cycle.
- R8: While a transaction runs, `req_valid`, `req_write`, `req_addr` and `req_wdata` have no effect. The bus shows the values captured at acceptance.
- R9: In idle, the output enable and the strobe are both 0.
- R10: A request presented in the first idle cycle after `rsp_done` is accepted at once, so transactions can follow one another with one idle cycle between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Core requests a transaction |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Transaction address |
| req_wdata | input | 16 | Word to write |
| rsp_rdata | output | 16 | Last word read from the peer |
| rsp_done | output | 1 | One-cycle completion pulse |
| bus_out | output | 16 | Value driven onto the shared lines |
| bus_oe | output | 1 | Drive enable for the shared lines |
| bus_in | input | 16 | Value seen on the shared lines |
| mode_strobe | output | 1 | Phase/direction strobe |

## Verification
A wrong phase register shows up within one cycle. The strobe or output enable falls out of the fixed pattern of 1/0, 1/1, dir/1 and 0/x, or `rsp_done` lands in the wrong cycle. A corrupted request latch shows up in the address or data phase as a wrong word on `bus_out`, or as the wrong strobe level in the direction phase. A bad capture path shows up on `rsp_rdata` in the cycle after the completion pulse, and as a changed value after a write.

// File: rtl/membus_pkg.sv
package membus_pkg;

    parameter int BUS_W = 16;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_PRIME = 3'd1,
        PH_ADDR  = 3'd2,
        PH_DIR   = 3'd3,
        PH_DATA  = 3'd4
    } phase_e;

    typedef struct packed {
        logic             write;
        logic [BUS_W-1:0] addr;
        logic [BUS_W-1:0] wdata;
    } xfer_t;

    typedef struct packed {
        logic             oe;
        logic             strobe;
        logic [BUS_W-1:0] word;
    } pins_t;

    function automatic phase_e next_phase(phase_e cur, logic start);
        case (cur)
            PH_IDLE:  return start ? PH_PRIME : PH_IDLE;
            PH_PRIME: return PH_ADDR;
            PH_ADDR:  return PH_DIR;
            PH_DIR:   return PH_DATA;
            default:  return PH_IDLE;
        endcase
    endfunction

    function automatic pins_t pins_for(phase_e ph, xfer_t x);
        pins_t p;
        p = '{oe: 1'b0, strobe: 1'b0, word: '0};
        case (ph)
            PH_PRIME: p.strobe = 1'b1;
            PH_ADDR: begin
                p.oe = 1'b1; p.strobe = 1'b1; p.word = x.addr;
            end
            PH_DIR: begin
                p.oe = 1'b1; p.strobe = ~x.write; p.word = x.addr;
            end
            PH_DATA: begin
                p.oe = x.write; p.word = x.write ? x.wdata : '0;
            end
            default: p = '{oe: 1'b0, strobe: 1'b0, word: '0};
        endcase
        return p;
    endfunction

endpackage

// File: rtl/membus_seq.sv
module membus_seq
    import membus_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   start,
    input  xfer_t  req,
    output phase_e phase,
    output xfer_t  held
);
    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            held  <= '0;
        end else begin
            phase <= next_phase(phase, start);
            if (phase == PH_IDLE && start)
                held <= req;
        end
    end
endmodule

// File: rtl/membus_drive.sv
module membus_drive
    import membus_pkg::*;
(
    input  phase_e phase,
    input  xfer_t  held,
    output pins_t  pins
);
    always_comb pins = pins_for(phase, held);
endmodule

// File: rtl/membus_capture.sv
module membus_capture
    import membus_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [BUS_W-1:0] din,
    output logic [BUS_W-1:0] dout
);
    always_ff @(posedge clk) begin
        if (rst)
            dout <= '0;
        else if (load)
            dout <= din;
    end
endmodule

// File: rtl/membus_master.sv
module membus_master
    import membus_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [BUS_W-1:0] req_addr,
    input  logic [BUS_W-1:0] req_wdata,
    output logic [BUS_W-1:0] rsp_rdata,
    output logic             rsp_done,
    output logic [BUS_W-1:0] bus_out,
    output logic             bus_oe,
    input  logic [BUS_W-1:0] bus_in,
    output logic             mode_strobe
);
    phase_e phase;
    xfer_t  req, held;
    pins_t  pins;

    assign req = '{write: req_write, addr: req_addr, wdata: req_wdata};

    membus_seq u_seq (
        .clk   (clk),
        .rst   (rst),
        .start (req_valid),
        .req   (req),
        .phase (phase),
        .held  (held)
    );

    membus_drive u_drv (
        .phase (phase),
        .held  (held),
        .pins  (pins)
    );

    membus_capture u_cap (
        .clk  (clk),
        .rst  (rst),
        .load (phase == PH_DATA && !held.write),
        .din  (bus_in),
        .dout (rsp_rdata)
    );

    assign bus_out     = pins.word;
    assign bus_oe      = pins.oe;
    assign mode_strobe = pins.strobe;
    assign rsp_done    = (phase == PH_DATA);
endmodule

// File: rtl/membus_checker.sv
module membus_checker
    import membus_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input phase_e           phase,
    input logic             lat_write,
    input logic [BUS_W-1:0] bus_out,
    input logic             bus_oe,
    input logic             mode_strobe,
    input logic             rsp_done
);
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_IDLE) |-> (!bus_oe && !mode_strobe)); // R9

    AST_PRIME_THEN_ADDR: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_PRIME) |=> (bus_oe && mode_strobe)); // R3

    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_DIR) |-> $stable(bus_out)); // R4

    AST_READ_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (rsp_done && !lat_write) |-> (!bus_oe && !mode_strobe)); // R6

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        rsp_done |=> !rsp_done); // R7

    AST_DONE_AFTER_DIR: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_DIR) |=> rsp_done); // R7
endmodule

bind membus_master membus_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .phase       (phase),
    .lat_write   (held.write),
    .bus_out     (bus_out),
    .bus_oe      (bus_oe),
    .mode_strobe (mode_strobe),
    .rsp_done    (rsp_done)
);

// File: tb/sim_membus_master.sv
`timescale 1ns/1ps
module sim_membus_master;
    localparam int CLK_PERIOD = 10;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         req_valid = 1'b0, req_write = 1'b0;
    logic [W-1:0] req_addr = '0, req_wdata = '0, bus_in = '0;
    logic [W-1:0] rsp_rdata, bus_out;
    logic         rsp_done, bus_oe, mode_strobe;

    int checks = 0, errors = 0;
    logic [W-1:0] last_rd = '0;
    bit done_flag = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    membus_master u0 (.*);

    task automatic chk(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic dir_strobe(input logic wr);
        return ~wr;
    endfunction

    // Starts at a negedge in idle; returns at the negedge of the idle cycle after done.
    task automatic txn(input logic wr, input logic [W-1:0] a, input logic [W-1:0] d,
                       input logic [W-1:0] rv, input bit noisy);
        req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
        @(posedge clk); @(negedge clk);
        // priming
        if (noisy) begin
            req_write = ~wr; req_addr = $urandom; req_wdata = $urandom;
        end else req_valid = 0;
        chk(mode_strobe == 1 && bus_oe == 0 && rsp_done == 0, "R2 prime", {14'd0, mode_strobe, bus_oe}, 16'h2);
        @(posedge clk); @(negedge clk);
        chk(bus_oe && mode_strobe, "R3 addr ctl", {14'd0, mode_strobe, bus_oe}, 16'h3);
        chk(bus_out == a, "R3/R8 addr word", bus_out, a);
        if (noisy) begin req_addr = $urandom; req_write = $urandom; end
        @(posedge clk); @(negedge clk);
        chk(mode_strobe == dir_strobe(wr) && bus_oe, "R4 dir strobe", {15'd0, mode_strobe}, {15'd0, dir_strobe(wr)});
        chk(bus_out == a, "R4 addr held", bus_out, a);
        @(posedge clk); @(negedge clk);
        req_valid = 0;
        chk(rsp_done == 1, "R7 done in data phase", {15'd0, rsp_done}, 16'd1);
        chk(mode_strobe == 0, "R5/R6 strobe low", {15'd0, mode_strobe}, 16'd0);
        if (wr) begin
            chk(bus_oe && bus_out == d, "R5/R8 write word", bus_out, d);
        end else begin
            chk(!bus_oe, "R6 released", {15'd0, bus_oe}, 16'd0);
            bus_in = rv;
            last_rd = rv;
        end
        @(posedge clk); @(negedge clk);
        bus_in = $urandom;
        chk(rsp_done == 0, "R7 done single", {15'd0, rsp_done}, 16'd0);
        chk(!bus_oe && !mode_strobe, "R9 idle quiet", {14'd0, mode_strobe, bus_oe}, 16'd0);
        chk(rsp_rdata == last_rd, "R6 read word", rsp_rdata, last_rd);
    endtask

    task automatic idle_cycles(input int n);
        req_valid = 0;
        for (int i = 0; i < n; i++) begin
            @(posedge clk); @(negedge clk);
            chk(!bus_oe && !mode_strobe && !rsp_done, "R9 idle", {13'd0, rsp_done, mode_strobe, bus_oe}, 16'd0);
        end
    endtask

    initial begin
        #(CLK_PERIOD*150000);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed1234));
        repeat (3) @(negedge clk);
        chk(!bus_oe && !mode_strobe && !rsp_done && rsp_rdata == 0, "R1 reset state",
            {13'd0, rsp_done, mode_strobe, bus_oe}, 16'd0);
        rst = 0;
        idle_cycles(2);
        // directed corners
        txn(1'b1, 16'hFFFE, 16'hA55A, 16'h0, 0);
        txn(1'b0, 16'h0000, 16'h0, 16'hBEEF, 0);           // R10 back-to-back
        txn(1'b1, 16'h1234, 16'h0001, 16'h0, 1);           // R8 noisy inputs
        chk(rsp_rdata == 16'hBEEF, "R6 held over write", rsp_rdata, 16'hBEEF);
        txn(1'b0, 16'h8000, 16'h0, 16'hFF00, 1);
        idle_cycles(1);
        // R1: reset mid-transaction
        req_valid = 1; req_write = 1; req_addr = 16'h4444;
        @(posedge clk); @(negedge clk);
        req_valid = 0;
        @(posedge clk); @(negedge clk);
        rst = 1;
        @(posedge clk); @(negedge clk);
        chk(!bus_oe && !mode_strobe && !rsp_done, "R1 reset mid-transaction",
            {13'd0, rsp_done, mode_strobe, bus_oe}, 16'd0);
        rst = 0;
        last_rd = '0;
        idle_cycles(2);
        // random mix
        for (int k = 0; k < 200; k++) begin
            txn(1'($urandom), 16'($urandom), 16'($urandom), 16'($urandom), 1'($urandom));
            if ($urandom_range(0, 2) == 0) idle_cycles($urandom_range(1, 3));
        end
        if (!done_flag) begin
            done_flag = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule